// File: doc/BRIEF.md
# DMA Channel Arbitration and Bus Lock Controller

This block decides, for one DMA channel, when the channel keeps its hold on the internal master-interface arbiter and when it holds the system bus through an hmastlock-style lock signal. Software chooses a span for each lock: the whole transfer, one buffer, or one finer unit. For the arbiter hold that unit is a chunk. For the bus lock it is a transaction, which is either a single access or a chunk. The transfer engine reports the start and end of each span through one-cycle event strobes. The block raises each lock on the start event of its span and drops it on the matching end event.

There are two lock scopes, and they nest. The arbiter hold always covers the bus lock, so a bus lock is never asserted without the arbiter hold, even when the arbiter hold is disabled or set to a narrower span. The level settings are captured when the channel is enabled and stay frozen while it runs. Dropping the channel enable or pulsing abort releases both locks in the same cycle.

Top module: `dma_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `arb_lock` and `bus_lock` are both low.
- R2: With the arbiter hold enabled at level 2'b00 (transfer), `arb_lock` rises in the cycle after `ev_xfer_start` and falls in the cycle after `ev_xfer_end`.
- R3: At arbiter-hold level 2'b01 the span runs from `ev_buf_start` to `ev_buf_end`. At level 2'b10 it runs from `ev_chunk_start` to `ev_chunk_end`. Single-access events do not move the arbiter hold.
- R4: The bus lock uses the same timing on `bus_lock`. Level 2'b00 follows the transfer events, 2'b01 follows the buffer events, and 2'b10 follows the transaction events, where either a single-access or a chunk start opens the span and either kind of end closes it.
- R5: Whenever `bus_lock` is high, `arb_lock` is high too. This holds even if the arbiter hold is disabled or set to a narrower span.
- R6: Level code 2'b11, or a cleared enable bit, produces no lock of that kind.
- R7: If `ch_en` is low or `abort` is high, both outputs are low in that same cycle. Neither lock comes back afterwards until a new start event arrives.
- R8: Enable bits and levels are captured in the cycle where `ch_en` rises, and a start event in that cycle already uses them. Changes made while `ch_en` stays high have no effect.
- R9: If an end event and a start event for the same span arrive in the same cycle, the lock stays high without a gap.
- R10: Events that arrive while `ch_en` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | 1 | Channel enable level |
| abort | input | 1 | Abort strobe, releases both locks |
| arb_hold_en | input | 1 | Arbiter hold enable setting |
| arb_hold_lvl | input | 2 | Arbiter hold span: 00 transfer, 01 buffer, 10 chunk, 11 none |
| bus_hold_en | input | 1 | Bus lock enable setting |
| bus_hold_lvl | input | 2 | Bus lock span: 00 transfer, 01 buffer, 10 transaction, 11 none |
| ev_xfer_start | input | 1 | Transfer begins |
| ev_xfer_end | input | 1 | Transfer ends |
| ev_buf_start | input | 1 | Buffer begins |
| ev_buf_end | input | 1 | Buffer ends |
| ev_chunk_start | input | 1 | Chunk begins |
| ev_chunk_end | input | 1 | Chunk ends |
| ev_single_start | input | 1 | Single access begins |
| ev_single_end | input | 1 | Single access ends |
| arb_lock | output | 1 | Hold request to the master-interface arbiter |
| bus_lock | output | 1 | Master bus lock |

## Verification
The hardest case to reach is a bus lock that outlives the arbiter hold's own span. The stimulus sets the bus lock to buffer level and the arbiter hold to chunk level, opens a buffer, and then runs a full chunk inside it. After the chunk ends, `arb_lock` must stay high until the buffer end. A second sequence changes both level fields while the channel is enabled and checks that the frozen settings still govern the locks. A third places a start event on the exact cycle in which `ch_en` rises.

// File: rtl/dma_lock_pkg.sv
`timescale 1ns/1ps
package dma_lock_pkg;
  localparam int LVL_W = 2;
  localparam int CFG_W = LVL_W + 1;
  localparam int NUM_LOCKS = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_XFER = 2'b00,
    LVL_BUF  = 2'b01,
    LVL_UNIT = 2'b10,
    LVL_NONE = 2'b11
  } lock_lvl_e;

  typedef struct packed {
    logic      en;
    lock_lvl_e lvl;
  } lock_cfg_t;

  typedef struct packed {
    logic xfer_s;
    logic xfer_e;
    logic buf_s;
    logic buf_e;
    logic chk_s;
    logic chk_e;
    logic sgl_s;
    logic sgl_e;
  } span_ev_t;

  // Start of the configured span; unit spans optionally include single accesses
  function automatic logic span_open(lock_cfg_t c, span_ev_t e, logic unit_has_single);
    logic r;
    r = 1'b0;
    if (c.en) begin
      unique case (c.lvl)
        LVL_XFER: r = e.xfer_s;
        LVL_BUF:  r = e.buf_s;
        LVL_UNIT: r = e.chk_s | (unit_has_single & e.sgl_s);
        default:  r = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic logic span_close(lock_cfg_t c, span_ev_t e, logic unit_has_single);
    logic r;
    r = 1'b0;
    if (c.en) begin
      unique case (c.lvl)
        LVL_XFER: r = e.xfer_e;
        LVL_BUF:  r = e.buf_e;
        LVL_UNIT: r = e.chk_e | (unit_has_single & e.sgl_e);
        default:  r = 1'b0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/lock_cfg_sampler.sv
`timescale 1ns/1ps
module lock_cfg_sampler import dma_lock_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_en,
  input  logic [CFG_W-1:0] ch_cfg_in,
  input  logic [CFG_W-1:0] bs_cfg_in,
  output logic             en_rise,
  output logic [CFG_W-1:0] ch_cfg_q,
  output logic [CFG_W-1:0] bs_cfg_q,
  output logic [CFG_W-1:0] ch_cfg_eff,
  output logic [CFG_W-1:0] bs_cfg_eff
);
  logic en_q;

  assign en_rise = ch_en & ~en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ch_cfg_q <= '0;
      bs_cfg_q <= '0;
    end else begin
      en_q <= ch_en;
      if (en_rise) begin
        ch_cfg_q <= ch_cfg_in;
        bs_cfg_q <= bs_cfg_in;
      end
    end
  end

  // Settings seen by the span logic: live on the enabling cycle, frozen after
  assign ch_cfg_eff = en_rise ? ch_cfg_in : ch_cfg_q;
  assign bs_cfg_eff = en_rise ? bs_cfg_in : bs_cfg_q;
endmodule

// File: rtl/lock_span_hold.sv
`timescale 1ns/1ps
module lock_span_hold import dma_lock_pkg::*; #(
  parameter bit UNIT_HAS_SINGLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CFG_W-1:0] cfg_raw,
  input  span_ev_t         ev,
  output logic             hold_q
);
  lock_cfg_t cfg;
  logic      open_ev;
  logic      close_ev;

  assign cfg      = lock_cfg_t'(cfg_raw);
  assign open_ev  = span_open(cfg, ev, UNIT_HAS_SINGLE);
  assign close_ev = span_close(cfg, ev, UNIT_HAS_SINGLE);

  // A new span opening in the closing cycle keeps the hold continuous
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (!active) hold_q <= 1'b0;
    else              hold_q <= open_ev | (hold_q & ~close_ev);
  end
endmodule

// File: rtl/dma_lock_ctrl.sv
`timescale 1ns/1ps
module dma_lock_ctrl import dma_lock_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ch_en,
  input  logic       abort,
  input  logic       arb_hold_en,
  input  logic [1:0] arb_hold_lvl,
  input  logic       bus_hold_en,
  input  logic [1:0] bus_hold_lvl,
  input  logic       ev_xfer_start,
  input  logic       ev_xfer_end,
  input  logic       ev_buf_start,
  input  logic       ev_buf_end,
  input  logic       ev_chunk_start,
  input  logic       ev_chunk_end,
  input  logic       ev_single_start,
  input  logic       ev_single_end,
  output logic       arb_lock,
  output logic       bus_lock
);
  logic             active;
  logic             en_rise;
  logic [CFG_W-1:0] ch_cfg_q, bs_cfg_q, ch_cfg_eff, bs_cfg_eff;
  logic [CFG_W-1:0] cfg_arr  [NUM_LOCKS];
  logic             hold_arr [NUM_LOCKS];
  logic             chan_hold, bus_hold;
  span_ev_t         ev;

  assign active = ch_en & ~abort;
  assign ev = '{xfer_s: ev_xfer_start,  xfer_e: ev_xfer_end,
                buf_s:  ev_buf_start,   buf_e:  ev_buf_end,
                chk_s:  ev_chunk_start, chk_e:  ev_chunk_end,
                sgl_s:  ev_single_start, sgl_e: ev_single_end};

  lock_cfg_sampler u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_en      (ch_en),
    .ch_cfg_in  ({arb_hold_en, arb_hold_lvl}),
    .bs_cfg_in  ({bus_hold_en, bus_hold_lvl}),
    .en_rise    (en_rise),
    .ch_cfg_q   (ch_cfg_q),
    .bs_cfg_q   (bs_cfg_q),
    .ch_cfg_eff (ch_cfg_eff),
    .bs_cfg_eff (bs_cfg_eff)
  );

  assign cfg_arr[0] = ch_cfg_eff;
  assign cfg_arr[1] = bs_cfg_eff;

  // Index 0: arbiter hold (unit = chunk); index 1: bus lock (unit = transaction)
  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_span
    lock_span_hold #(.UNIT_HAS_SINGLE(i == 1)) u_span (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .cfg_raw (cfg_arr[i]),
      .ev      (ev),
      .hold_q  (hold_arr[i])
    );
  end

  assign chan_hold = hold_arr[0];
  assign bus_hold  = hold_arr[1];

  // Arbiter hold is stretched to cover any bus lock
  assign bus_lock = active & bus_hold;
  assign arb_lock = active & (chan_hold | bus_hold);
endmodule

// File: rtl/dma_lock_chk.sv
`timescale 1ns/1ps
module dma_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ch_en,
  input logic       abort,
  input logic       ev_xfer_start,
  input logic       en_rise,
  input logic [2:0] ch_cfg_q,
  input logic [2:0] bs_cfg_q,
  input logic [2:0] ch_cfg_eff,
  input logic       chan_hold,
  input logic       bus_hold,
  input logic       arb_lock,
  input logic       bus_lock
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!arb_lock && !bus_lock)); // R1

  AST_XFER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !abort && ch_cfg_eff == 3'b100 && ev_xfer_start) |=> (arb_lock || !ch_en || abort)); // R2

  AST_BUS_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock |-> arb_lock); // R5

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !en_rise && (!ch_cfg_q[2] || ch_cfg_q[1:0] == 2'b11) && !bus_lock) |-> !arb_lock); // R6

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en || abort) |-> (!arb_lock && !bus_lock)); // R7

  AST_HOLD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en || abort) |=> (!chan_hold && !bus_hold)); // R7

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !en_rise) |=> ($stable(ch_cfg_q) && $stable(bs_cfg_q)) || !ch_en || en_rise); // R8
endmodule

bind dma_lock_ctrl dma_lock_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ch_en         (ch_en),
  .abort         (abort),
  .ev_xfer_start (ev_xfer_start),
  .en_rise       (en_rise),
  .ch_cfg_q      (ch_cfg_q),
  .bs_cfg_q      (bs_cfg_q),
  .ch_cfg_eff    (ch_cfg_eff),
  .chan_hold     (chan_hold),
  .bus_hold      (bus_hold),
  .arb_lock      (arb_lock),
  .bus_lock      (bus_lock)
);

// File: tb/dma_lock_ctrl_bench.sv
`timescale 1ns/1ps
module dma_lock_ctrl_bench;
  localparam logic [7:0] XS = 8'h80, XE = 8'h40, BS = 8'h20, BE = 8'h10;
  localparam logic [7:0] CS = 8'h08, CE = 8'h04, SS = 8'h02, SE = 8'h01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_en = 1'b0, abort = 1'b0;
  logic arb_hold_en = 1'b0, bus_hold_en = 1'b0;
  logic [1:0] arb_hold_lvl = 2'b11, bus_hold_lvl = 2'b11;
  logic [7:0] evv = 8'h00;
  logic arb_lock, bus_lock;

  int tests = 0, fails = 0;
  logic [1:0] q_exp[$];
  string      q_req[$];

  // reference state
  logic m_en_q = 1'b0, m_chh = 1'b0, m_bsh = 1'b0;
  logic [2:0] m_chc = 3'b0, m_bsc = 3'b0;

  always #4 clk = ~clk;

  dma_lock_ctrl u_dma_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .abort(abort),
    .arb_hold_en(arb_hold_en), .arb_hold_lvl(arb_hold_lvl),
    .bus_hold_en(bus_hold_en), .bus_hold_lvl(bus_hold_lvl),
    .ev_xfer_start(evv[7]), .ev_xfer_end(evv[6]),
    .ev_buf_start(evv[5]), .ev_buf_end(evv[4]),
    .ev_chunk_start(evv[3]), .ev_chunk_end(evv[2]),
    .ev_single_start(evv[1]), .ev_single_end(evv[0]),
    .arb_lock(arb_lock), .bus_lock(bus_lock));

  // events for a given level: returns {start, end}
  function automatic logic [1:0] m_edges(logic [2:0] c, logic [7:0] e, bit is_bus);
    if (c[2] == 1'b0) return 2'b00;
    case (c[1:0])
      2'd0: return {e[7], e[6]};
      2'd1: return {e[5], e[4]};
      2'd2: return is_bus ? {e[3] | e[1], e[2] | e[0]} : {e[3], e[2]};
      default: return 2'b00;
    endcase
  endfunction

  task automatic cyc(input logic [7:0] e, input logic en, input logic ab, input string req);
    logic [2:0] cc, bc;
    logic [1:0] ce, be;
    logic go;
    @(negedge clk);
    evv = e; ch_en = en; abort = ab;
    if (en && !m_en_q) begin
      m_chc = {arb_hold_en, arb_hold_lvl};
      m_bsc = {bus_hold_en, bus_hold_lvl};
    end
    cc = m_chc; bc = m_bsc;
    go = en && !ab;
    ce = m_edges(cc, e, 1'b0);
    be = m_edges(bc, e, 1'b1);
    m_chh = go && (ce[1] || (m_chh && !ce[0]));
    m_bsh = go && (be[1] || (m_bsh && !be[0]));
    m_en_q = en;
    q_exp.push_back({go && (m_chh || m_bsh), go && m_bsh});
    q_req.push_back(req);
  endtask

  // monitor: compare after each edge, well clear of it
  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      logic [1:0] x;
      string r;
      x = q_exp.pop_front();
      r = q_req.pop_front();
      tests++;
      if ({arb_lock, bus_lock} !== x) begin
        fails++;
        $display("FAIL %s: arb/bus got %b%b expected %b%b", r, arb_lock, bus_lock, x[1], x[0]);
      end
    end
  end

  task automatic setcfg(input logic ce_, input logic [1:0] cl, input logic be_, input logic [1:0] bl);
    @(negedge clk);
    arb_hold_en = ce_; arb_hold_lvl = cl; bus_hold_en = be_; bus_hold_lvl = bl;
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (arb_lock !== 1'b0 || bus_lock !== 1'b0) begin
      fails++;
      $display("FAIL R1: in reset arb/bus got %b%b expected 00", arb_lock, bus_lock);
    end
    rst_n = 1'b1;
    cyc(0, 0, 0, "R1");

    // R2: transfer span for arbiter hold
    setcfg(1, 2'b00, 0, 2'b00);
    cyc(0, 1, 0, "R2");
    cyc(XS, 1, 0, "R2");
    cyc(BS, 1, 0, "R2");
    cyc(BE, 1, 0, "R2");
    cyc(XE, 1, 0, "R2");
    cyc(0, 1, 0, "R2");
    cyc(0, 0, 0, "R2");

    // R3: buffer span, then chunk span; single events do nothing
    setcfg(1, 2'b01, 0, 2'b00);
    cyc(BS, 1, 0, "R3");
    cyc(CS | XS, 1, 0, "R3");
    cyc(BE, 1, 0, "R3");
    cyc(0, 0, 0, "R3");
    setcfg(1, 2'b10, 0, 2'b00);
    cyc(SS, 1, 0, "R3");
    cyc(SE | CS, 1, 0, "R3");
    cyc(0, 1, 0, "R3");
    cyc(CE, 1, 0, "R3");
    cyc(0, 0, 0, "R3");

    // R4/R5: transaction bus lock with arbiter hold disabled
    setcfg(0, 2'b00, 1, 2'b10);
    cyc(SS, 1, 0, "R4 R5");
    cyc(SE, 1, 0, "R4");
    cyc(CS, 1, 0, "R4 R5");
    cyc(0, 1, 0, "R4");
    cyc(CE, 1, 0, "R4");
    cyc(0, 0, 0, "R4");
    setcfg(0, 2'b00, 1, 2'b00);
    cyc(XS, 1, 0, "R4");
    cyc(CS | CE, 1, 0, "R4");
    cyc(XE, 1, 0, "R4");
    cyc(0, 0, 0, "R4");

    // R5: bus lock per buffer outlasts chunk-level arbiter hold
    setcfg(1, 2'b10, 1, 2'b01);
    cyc(BS, 1, 0, "R5");
    cyc(CS, 1, 0, "R5");
    cyc(CE, 1, 0, "R5");
    cyc(0, 1, 0, "R5");
    cyc(BE, 1, 0, "R5");
    cyc(0, 0, 0, "R5");

    // R6: reserved codes and cleared enables
    setcfg(1, 2'b11, 1, 2'b11);
    cyc(XS | BS | CS | SS, 1, 0, "R6");
    cyc(0, 1, 0, "R6");
    cyc(0, 0, 0, "R6");
    setcfg(0, 2'b01, 0, 2'b01);
    cyc(BS, 1, 0, "R6");
    cyc(0, 1, 0, "R6");
    cyc(0, 0, 0, "R6");

    // R7: abort and disable release immediately and stay released
    setcfg(1, 2'b00, 1, 2'b00);
    cyc(XS, 1, 0, "R7");
    cyc(0, 1, 1, "R7");
    cyc(0, 1, 0, "R7");
    cyc(XS, 1, 0, "R7");
    cyc(0, 0, 0, "R7");
    cyc(0, 1, 0, "R7");

    // R10: events with channel disabled
    cyc(0, 0, 0, "R10");
    cyc(XS | BS | CS | SS, 0, 0, "R10");
    cyc(0, 1, 0, "R10");

    // R8: frozen settings, and start on the enabling cycle
    cyc(0, 0, 0, "R8");
    setcfg(1, 2'b00, 0, 2'b00);
    cyc(XS, 1, 0, "R8");
    setcfg(1, 2'b11, 1, 2'b10);
    cyc(SS | CS, 1, 0, "R8");
    cyc(CE | SE, 1, 0, "R8");
    cyc(XE, 1, 0, "R8");
    cyc(0, 0, 0, "R8");
    setcfg(1, 2'b10, 0, 2'b00);
    cyc(0, 1, 0, "R8");
    setcfg(1, 2'b00, 1, 2'b00);
    cyc(XS, 1, 0, "R8");
    cyc(0, 1, 0, "R8");
    cyc(0, 0, 0, "R8");

    // R9: back-to-back chunks
    setcfg(1, 2'b10, 0, 2'b00);
    cyc(CS, 1, 0, "R9");
    cyc(CE | CS, 1, 0, "R9");
    cyc(CE, 1, 0, "R9");
    cyc(0, 1, 0, "R9");
    cyc(0, 0, 0, "R9");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule